// File: doc/BRIEF.md
# Bidirectional LCD Row Scan Driver

This block is the digital core of a row (common) driver for a passive dot-matrix LCD. A chain of 68 one-bit stages carries a scanning token. Each falling edge of the scan clock moves the token one stage, and every stage drives one row. A direction input sets whether the token travels from row 0 toward row 67 or the other way. The same input decides which of two bidirectional serial pins accepts the incoming token and which passes the outgoing token on to the next driver in a chain. Chaining lets one token scan frames much taller than a single driver, such as 200 lines at 1/200 duty.

Each row gets a 2-bit drive-level code. Analog stages outside this block turn that code into one of four bias voltages. The code depends on the row's stage bit and on the AC-inversion input. An active-low blanking input clears the whole chain at once, without waiting for a clock. A build-time option picks what blanked rows show. In one variant they fall back to the normal non-select levels. In the other they are all forced to the lowest-magnitude level, V0.

The scan clock is sampled by the system clock `clk`, and a shift takes place on the first `clk` rising edge at which the scan clock reads low after reading high one cycle earlier.

Top module: `row_scan_driver`

## Requirements
- R1: While `rst` is high at a `clk` rising edge, every stage is cleared, so that after the edge no row carries a select code and both data outputs read 0.
- R2: The stages change only at a `clk` edge where `scan_clk` is sampled 0 after being sampled 1 at the previous edge (a scan-clock fall), or through blanking; at any other edge the row codes hold as long as `ac` holds.
- R3: With `dir` = 0, `sd_a_i` is the data input, `sd_b_oe` = 1, `sd_a_oe` = 0, and each scan-clock fall moves row k into row k+1 and loads `sd_a_i` into row 0.
- R4: With `dir` = 1, `sd_b_i` is the data input, `sd_a_oe` = 1, `sd_b_oe` = 0, and each scan-clock fall moves row k into row k-1 and loads `sd_b_i` into row 67.
- R5: The enabled data output presents the last stage in the active direction: `sd_b_o` = row 67's bit when `dir` = 0, and `sd_a_o` = row 0's bit when `dir` = 1. The disabled pin's output reads 0. After a single 1 is fed in, it reaches the carry output after exactly 68 scan-clock falls and leaves it on the 69th.
- R6: Driving `blank_n` low clears every stage immediately, before any clock edge. While `blank_n` stays low, scan-clock falls and data inputs have no effect, so all rows stay non-select after release.
- R7: A row whose bit is 1 shows the select code: 2'b11 (V5) when `ac` = 1 and 2'b00 (V0) when `ac` = 0. Row k occupies `row_code[2k+1:2k]`.
- R8: A row whose bit is 0 shows the non-select code: 2'b01 (V1) when `ac` = 1 and 2'b10 (V4) when `ac` = 0.
- R9: With `BLANK_MODE` = display-off, every row shows 2'b00 while `blank_n` is low, whatever `ac` is. With `BLANK_MODE` = inhibit, blanked rows follow R8.
- R10: Exactly one of `sd_a_oe` and `sd_b_oe` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the scan clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_clk | input | 1 | Scan shift clock; shifting happens on its falling edge |
| dir | input | 1 | Shift direction and serial pin role select |
| blank_n | input | 1 | Active-low asynchronous blanking/clear |
| ac | input | 1 | AC-inversion phase |
| sd_a_i | input | 1 | Serial pin A input side |
| sd_a_o | output | 1 | Serial pin A output side |
| sd_a_oe | output | 1 | Serial pin A output enable |
| sd_b_i | input | 1 | Serial pin B input side |
| sd_b_o | output | 1 | Serial pin B output side |
| sd_b_oe | output | 1 | Serial pin B output enable |
| row_code | output | 2*ROWS | Drive-level code per row, row k at bits [2k+1:2k] |

## Verification
Some rules hold on every cycle, and the assertions check those:
- each row code is always one of the two codes allowed for the current `ac` phase;
- the carry output agrees with the end row's code;
- exactly one pin enable is up;
- blanking forces the variant's level;
- the rows sit still between scan-clock falls.

Other behaviour only shows up in the bench's scenarios:
- a token crossing all 68 rows in each direction and reaching the carry output on the 68th fall;
- the immediate clear when blanking arrives in the middle of a frame;
- inputs being ignored while blanked;
- a direction change with bits already in flight.

// File: rtl/row_drv_pkg.sv
package row_drv_pkg;

  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V1 = 2'b01,
    LVL_V4 = 2'b10,
    LVL_V5 = 2'b11
  } drive_lvl_e;

  typedef enum logic {
    BLANK_INHIBIT     = 1'b0,
    BLANK_DISPLAY_OFF = 1'b1
  } blank_mode_e;

  // Level code for one row from its stage bit, phase and blanking state.
  function automatic drive_lvl_e level_for(input logic bit_v, input logic ac,
                                           input logic blanked, input blank_mode_e mode);
    if (blanked && mode == BLANK_DISPLAY_OFF) return LVL_V0;
    if (bit_v) return ac ? LVL_V5 : LVL_V0;
    return ac ? LVL_V1 : LVL_V4;
  endfunction

endpackage

// File: rtl/scan_fall_detect.sv
module scan_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic scan_clk,
  output logic fall
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b0;
    else     scl_q <= scan_clk;
  end

  assign fall = scl_q & ~scan_clk;
endmodule

// File: rtl/row_shift_chain.sv
module row_shift_chain #(
  parameter int ROWS = 68
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_n,
  input  logic            step,
  input  logic            dir,
  input  logic            fwd_in,
  input  logic            rev_in,
  output logic [ROWS-1:0] stg
);
  localparam int LAST = ROWS - 1;

  logic [ROWS-1:0] nxt;

  always_comb begin
    if (!dir) nxt = {stg[LAST-1:0], fwd_in};
    else      nxt = {rev_in, stg[LAST:1]};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    stg <= '0;
    else if (rst)  stg <= '0;
    else if (step) stg <= nxt;
  end
endmodule

// File: rtl/serial_pin_ctrl.sv
module serial_pin_ctrl (
  input  logic dir,
  input  logic head_bit,
  input  logic tail_bit,
  output logic a_o,
  output logic a_oe,
  output logic b_o,
  output logic b_oe
);
  // dir=0: A feeds the chain, B carries out the tail; dir=1: reversed.
  assign a_oe = dir;
  assign b_oe = ~dir;
  assign a_o  = dir & head_bit;
  assign b_o  = ~dir & tail_bit;
endmodule

// File: rtl/row_level_encoder.sv
module row_level_encoder
  import row_drv_pkg::*;
#(
  parameter int          ROWS = 68,
  parameter blank_mode_e MODE = BLANK_INHIBIT
) (
  input  logic [ROWS-1:0]   stg,
  input  logic              ac,
  input  logic              blank_n,
  output logic [2*ROWS-1:0] row_code
);
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_code[2*i +: 2] = level_for(stg[i], ac, ~blank_n, MODE);
  end
endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver
  import row_drv_pkg::*;
#(
  parameter int          ROWS       = 68,
  parameter blank_mode_e BLANK_MODE = BLANK_INHIBIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_clk,
  input  logic              dir,
  input  logic              blank_n,
  input  logic              ac,
  input  logic              sd_a_i,
  output logic              sd_a_o,
  output logic              sd_a_oe,
  input  logic              sd_b_i,
  output logic              sd_b_o,
  output logic              sd_b_oe,
  output logic [2*ROWS-1:0] row_code
);
  localparam int LAST = ROWS - 1;

  logic            step;
  logic [ROWS-1:0] stg;

  scan_fall_detect u_fall (
    .clk      (clk),
    .rst      (rst),
    .scan_clk (scan_clk),
    .fall     (step)
  );

  row_shift_chain #(.ROWS(ROWS)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (blank_n),
    .step   (step),
    .dir    (dir),
    .fwd_in (sd_a_i),
    .rev_in (sd_b_i),
    .stg    (stg)
  );

  serial_pin_ctrl u_pins (
    .dir      (dir),
    .head_bit (stg[0]),
    .tail_bit (stg[LAST]),
    .a_o      (sd_a_o),
    .a_oe     (sd_a_oe),
    .b_o      (sd_b_o),
    .b_oe     (sd_b_oe)
  );

  row_level_encoder #(.ROWS(ROWS), .MODE(BLANK_MODE)) u_enc (
    .stg      (stg),
    .ac       (ac),
    .blank_n  (blank_n),
    .row_code (row_code)
  );
endmodule

// File: rtl/row_scan_driver_chk.sv
module row_scan_driver_chk
  import row_drv_pkg::*;
#(
  parameter int          ROWS = 68,
  parameter blank_mode_e MODE = BLANK_INHIBIT
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_clk,
  input logic              dir,
  input logic              blank_n,
  input logic              ac,
  input logic              sd_a_o,
  input logic              sd_a_oe,
  input logic              sd_b_o,
  input logic              sd_b_oe,
  input logic [2*ROWS-1:0] row_code
);
  localparam int LAST = ROWS - 1;

  function automatic int sel_count(input logic [2*ROWS-1:0] codes, input logic phase);
    int n = 0;
    for (int k = 0; k < ROWS; k++)
      if (codes[2*k +: 2] == (phase ? 2'b11 : 2'b00)) n++;
    return n;
  endfunction

  logic [1:0] sel_c, non_c;
  assign sel_c = ac ? 2'b11 : 2'b00;
  assign non_c = ac ? 2'b01 : 2'b10;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!blank_n || sel_count(row_code, ac) == 0)); // R1

  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    (blank_n && !($past(scan_clk) && !scan_clk)) |=>
      (!blank_n || ac != $past(ac) || $stable(row_code))); // R2

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({sd_a_oe, sd_b_oe}) == 1); // R10

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    dir |-> (sd_a_oe && !sd_b_oe)); // R4

  AST_CARRY_FWD: assert property (@(posedge clk) disable iff (rst)
    (blank_n && !dir) |-> (sd_b_o == (row_code[2*LAST +: 2] == sel_c) && !sd_a_o)); // R5

  AST_CARRY_REV: assert property (@(posedge clk) disable iff (rst)
    (blank_n && dir) |-> (sd_a_o == (row_code[1:0] == sel_c) && !sd_b_o)); // R5

  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> (MODE == BLANK_DISPLAY_OFF ? row_code == '0
                                             : row_code == {ROWS{non_c}})); // R9

  for (genvar i = 0; i < ROWS; i++) begin : g_rowchk
    AST_ROW_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
      blank_n |-> (row_code[2*i +: 2] == sel_c || row_code[2*i +: 2] == non_c)); // R7 R8
  end
endmodule

bind row_scan_driver row_scan_driver_chk #(.ROWS(ROWS), .MODE(BLANK_MODE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scan_clk (scan_clk),
  .dir      (dir),
  .blank_n  (blank_n),
  .ac       (ac),
  .sd_a_o   (sd_a_o),
  .sd_a_oe  (sd_a_oe),
  .sd_b_o   (sd_b_o),
  .sd_b_oe  (sd_b_oe),
  .row_code (row_code)
);

// File: tb/row_scan_driver_tb.sv
module row_scan_driver_tb;
  localparam int N = 68;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_clk = 1'b0;
  logic dir = 1'b0;
  logic blank_n = 1'b1;
  logic ac = 1'b0;
  logic sd_a_i = 1'b0;
  logic sd_b_i = 1'b0;

  logic a_o_i, a_oe_i, b_o_i, b_oe_i;
  logic a_o_d, a_oe_d, b_o_d, b_oe_d;
  logic [2*N-1:0] code_i, code_d;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  row_scan_driver #(.ROWS(N), .BLANK_MODE(row_drv_pkg::BLANK_INHIBIT)) u_dut (
    .clk(clk), .rst(rst), .scan_clk(scan_clk), .dir(dir), .blank_n(blank_n), .ac(ac),
    .sd_a_i(sd_a_i), .sd_a_o(a_o_i), .sd_a_oe(a_oe_i),
    .sd_b_i(sd_b_i), .sd_b_o(b_o_i), .sd_b_oe(b_oe_i), .row_code(code_i));

  row_scan_driver #(.ROWS(N), .BLANK_MODE(row_drv_pkg::BLANK_DISPLAY_OFF)) u_dut_off (
    .clk(clk), .rst(rst), .scan_clk(scan_clk), .dir(dir), .blank_n(blank_n), .ac(ac),
    .sd_a_i(sd_a_i), .sd_a_o(a_o_d), .sd_a_oe(a_oe_d),
    .sd_b_i(sd_b_i), .sd_b_o(b_o_d), .sd_b_oe(b_oe_d), .row_code(code_d));

  // Behavioural reference: one integer per row, shifted as a list.
  int mdl[N];
  int prev_scl = 0;

  always @(posedge clk) begin
    if (!blank_n || rst) begin
      for (int k = 0; k < N; k++) mdl[k] = 0;
    end else if (prev_scl == 1 && scan_clk == 1'b0) begin
      if (!dir) begin
        for (int k = N-1; k > 0; k--) mdl[k] = mdl[k-1];
        mdl[0] = sd_a_i;
      end else begin
        for (int k = 0; k < N-1; k++) mdl[k] = mdl[k+1];
        mdl[N-1] = sd_b_i;
      end
    end
    prev_scl = rst ? 0 : int'(scan_clk);
  end

  function automatic logic [1:0] exp_code(int b, logic phase, logic blanked, bit off_variant);
    if (blanked && off_variant) return 2'b00;
    if (blanked) b = 0;
    if (b != 0) return phase ? 2'b11 : 2'b00;
    return phase ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [2*N-1:0] exp_rows(bit off_variant);
    logic [2*N-1:0] r;
    for (int k = 0; k < N; k++) r[2*k +: 2] = exp_code(mdl[k], ac, !blank_n, off_variant);
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Pin checks against the model on every clock (R3 R4 R5 R10 / R7 R8 R9 rows).
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      logic [3:0] pins_e;
      int head, tail;
      head = blank_n ? mdl[0] : 0;
      tail = blank_n ? mdl[N-1] : 0;
      pins_e = {dir & (head != 0), dir, ~dir & (tail != 0), ~dir};
      chk(code_i == exp_rows(0), "R7 R8 R9 rows inhibit variant", code_i, exp_rows(0));
      chk(code_d == exp_rows(1), "R7 R8 R9 rows display-off variant", code_d, exp_rows(1));
      chk({a_o_i, a_oe_i, b_o_i, b_oe_i} == pins_e, "R3 R4 R5 R10 pins inhibit",
          {a_o_i, a_oe_i, b_o_i, b_oe_i}, pins_e);
      chk({a_o_d, a_oe_d, b_o_d, b_oe_d} == pins_e, "R3 R4 R5 R10 pins display-off",
          {a_o_d, a_oe_d, b_o_d, b_oe_d}, pins_e);
    end
  end

  task automatic pulse(logic din);
    @(negedge clk);
    sd_a_i = din; sd_b_i = din; scan_clk = 1'b1;
    @(negedge clk);
    scan_clk = 1'b0;
    @(negedge clk);
    sd_a_i = 1'b0; sd_b_i = 1'b0;
  endtask

  function automatic logic [1:0] row_of(logic [2*N-1:0] c, int k);
    return c[2*k +: 2];
  endfunction

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset leaves every row non-select.
    chk(code_i == {N{2'b10}}, "R1 reset rows", code_i, {N{2'b10}});
    chk(!b_o_i && !a_o_i, "R1 reset data outputs", {a_o_i, b_o_i}, '0);

    // R2: scan clock held high, no fall, nothing moves.
    @(negedge clk); scan_clk = 1'b1; sd_a_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(code_i == {N{2'b10}}, "R2 no shift without fall", code_i, {N{2'b10}});
    scan_clk = 1'b0; sd_a_i = 1'b0;
    @(negedge clk);
    chk(row_of(code_i, 0) == 2'b10, "R2 fall with data low loads 0", row_of(code_i, 0), 2'b10);

    // R3 R5: forward token across all rows.
    pulse(1'b1);
    chk(row_of(code_i, 0) == 2'b00, "R3 token enters row 0", row_of(code_i, 0), 2'b00);
    for (int p = 2; p <= 67; p++) pulse(1'b0);
    chk(b_o_i == 1'b0, "R5 carry still low after 67 falls", b_o_i, 1'b0);
    pulse(1'b0);
    chk(b_o_i == 1'b1 && row_of(code_i, 67) == 2'b00, "R5 carry high after 68 falls",
        {b_o_i, row_of(code_i, 67)}, 3'b100);
    pulse(1'b0);
    chk(b_o_i == 1'b0, "R5 carry drops on 69th fall", b_o_i, 1'b0);

    // R4 R5: reverse token.
    @(negedge clk); dir = 1'b1;
    pulse(1'b1);
    chk(row_of(code_i, 67) == 2'b00 && a_oe_i, "R4 token enters row 67",
        {a_oe_i, row_of(code_i, 67)}, 3'b100);
    for (int p = 2; p <= 68; p++) pulse(1'b0);
    chk(a_o_i == 1'b1, "R5 reverse carry after 68 falls", a_o_i, 1'b1);
    pulse(1'b0);

    // R7 R8: both phases on a selected row.
    @(negedge clk); dir = 1'b0;
    pulse(1'b1); pulse(1'b0);
    @(negedge clk); ac = 1'b1;
    @(negedge clk);
    chk(row_of(code_i, 1) == 2'b11, "R7 select with ac high", row_of(code_i, 1), 2'b11);
    chk(row_of(code_i, 0) == 2'b01, "R8 non-select with ac high", row_of(code_i, 0), 2'b01);
    ac = 1'b0;
    @(negedge clk);
    chk(row_of(code_i, 1) == 2'b00, "R7 select with ac low", row_of(code_i, 1), 2'b00);
    chk(row_of(code_i, 0) == 2'b10, "R8 non-select with ac low", row_of(code_i, 0), 2'b10);

    // R6 R9: blanking mid-frame, immediate clear, inputs ignored.
    for (int p = 0; p < 30; p++) pulse(p % 3 == 0);
    @(negedge clk); ac = 1'b1;
    #1 blank_n = 1'b0;
    #1;
    chk(code_i == {N{2'b01}}, "R6 immediate clear inhibit", code_i, {N{2'b01}});
    chk(code_d == '0, "R9 display-off forces V0 ac high", code_d, '0);
    pulse(1'b1); pulse(1'b1);
    @(negedge clk); ac = 1'b0;
    @(negedge clk);
    chk(code_d == '0, "R9 display-off forces V0 ac low", code_d, '0);
    chk(code_i == {N{2'b10}}, "R9 inhibit follows non-select", code_i, {N{2'b10}});
    blank_n = 1'b1;
    @(negedge clk);
    chk(code_i == {N{2'b10}}, "R6 inputs ignored while blanked", code_i, {N{2'b10}});

    // Direction change with several bits in flight (R3 R4).
    pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b1);
    @(negedge clk); dir = 1'b1;
    for (int p = 0; p < 6; p++) pulse(1'b0);
    @(negedge clk); ac = 1'b1; dir = 1'b0;
    for (int p = 0; p < 4; p++) pulse(p[0]);

    // R1: reset in mid-frame.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(code_i == {N{2'b01}}, "R1 reset mid-frame", code_i, {N{2'b01}});

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule